// File: doc/BRIEF.md
# Dual-Width Stack Push Sequencer

This block performs the memory side of a register push for a processor core that runs in either a 24-bit (long) or a 16-bit (short) addressing mode. It owns two stack pointers: a 24-bit one used by long pushes and a 16-bit one used by short pushes. When a push is requested, it writes the register value to memory one byte per clock, most significant byte first, at descending addresses just below the selected stack pointer. It then lowers that pointer by the number of bytes it wrote.

The push width normally follows the core's current mode flag. A per-instruction suffix code can force either width for a single push. A short push forms its full 24-bit address by putting an 8-bit memory base value in front of the 16-bit pointer. Fetch, prefix decoding and the memory itself belong to the surrounding core. The memory port is a plain synchronous byte-write strobe with address and data.

Top module: `dual_stack_pusher`

## Requirements
- R1: A long push of value V emits three byte writes on consecutive cycles: V[23:16] to sp_long-1, then V[15:8] to sp_long-2, then V[7:0] to sp_long-3, all computed modulo 2^24.
- R2: After a long push, sp_long equals its previous value minus 3 (modulo 2^24), and sp_short is unchanged.
- R3: A short push of value V emits two byte writes on consecutive cycles: V[15:8] to {mem_base, sp_short-1}, then V[7:0] to {mem_base, sp_short-2}. The 16-bit part wraps modulo 2^16 and never borrows into the base byte.
- R4: After a short push, sp_short equals its previous value minus 2 (modulo 2^16), and sp_long is unchanged.
- R5: The suffix code sfx_sel selects the width: 2'b01 forces short, 2'b10 forces long, and 2'b00 or 2'b11 use mode_long (1 = long, 0 = short).
- R6: A request is accepted at a clock edge where busy is low. The first write appears in the cycle after that edge. busy is high for exactly as many cycles as bytes are written (3 or 2), and the updated stack pointer is visible during the final write cycle.
- R7: A request presented while busy is high, including during the final write cycle, is ignored: it causes no write and no pointer change.
- R8: push_val, mode_long, sfx_sel and mem_base are captured at acceptance. Changing them while busy has no effect on the push in progress.
- R9: After reset, busy and mem_we are low, sp_long equals SPL_INIT and sp_short equals SPS_INIT.
- R10: mem_we is never high while busy is low. Consecutive writes step the address down by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_req | input | 1 | Push request, taken when busy is low |
| push_val | input | ADDR_W (24) | Register value to push |
| mode_long | input | 1 | Current mode: 1 long, 0 short |
| sfx_sel | input | 2 | Width override: 00 none, 01 short, 10 long, 11 none |
| mem_base | input | ADDR_W-SHORT_W (8) | Upper address byte used by short pushes |
| busy | output | 1 | High while a push's writes are in progress |
| mem_we | output | 1 | Byte write strobe |
| mem_addr | output | ADDR_W (24) | Byte write address |
| mem_wdata | output | 8 | Byte write data |
| sp_long | output | ADDR_W (24) | Long stack pointer |
| sp_short | output | SHORT_W (16) | Short stack pointer |

## Verification
The bench keeps the default 24/16-bit pointer widths but builds the block with SPL_INIT = 2 and SPS_INIT = 1. This makes the very first long push and the very first short push cross zero. Wrap-around in both pointers, including the short address that must not borrow into the base byte, is therefore reached without any preloading path. Later pushes then run from high pointer values near the top of each range. Stray requests are placed in the first, middle and final write cycles, with all operands changed at the same time, so the capture-and-ignore rules are exercised for both widths.

// File: rtl/push_pkg.sv
`timescale 1ns/1ps
package push_pkg;
  localparam int BYTE_W = 8;

  // Width override carried with one push instruction
  typedef enum logic [1:0] {
    SFX_NONE  = 2'b00,
    SFX_SHORT = 2'b01,
    SFX_LONG  = 2'b10,
    SFX_RSVD  = 2'b11
  } sfx_e;
endpackage

// File: rtl/push_width_res.sv
`timescale 1ns/1ps
module push_width_res
  import push_pkg::*;
(
  input  logic       mode_long,
  input  logic [1:0] sfx_sel,
  output logic       use_long
);
  always_comb begin
    case (sfx_e'(sfx_sel))
      SFX_SHORT: use_long = 1'b0;
      SFX_LONG:  use_long = 1'b1;
      default:   use_long = mode_long;
    endcase
  end
endmodule

// File: rtl/push_addr_gen.sv
`timescale 1ns/1ps
module push_addr_gen #(
  parameter int ADDR_W  = 24,
  parameter int SHORT_W = 16,
  parameter int OFF_W   = 2
) (
  input  logic                      use_long,
  input  logic [ADDR_W-1:0]         sp_l,
  input  logic [SHORT_W-1:0]        sp_s,
  input  logic [ADDR_W-SHORT_W-1:0] base,
  input  logic [OFF_W-1:0]          off,
  output logic [ADDR_W-1:0]         addr
);
  logic [ADDR_W-1:0]  a_long;
  logic [SHORT_W-1:0] a_short;

  // each pointer wraps inside its own width; short never borrows into base
  assign a_long  = sp_l - ADDR_W'(off);
  assign a_short = sp_s - SHORT_W'(off);
  assign addr    = use_long ? a_long : {base, a_short};
endmodule

// File: rtl/push_byte_pick.sv
`timescale 1ns/1ps
module push_byte_pick
  import push_pkg::*;
#(
  parameter int VAL_W = 24,
  parameter int IDX_W = 2
) (
  input  logic [VAL_W-1:0]  val,
  input  logic [IDX_W-1:0]  idx,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int NLANE = VAL_W / BYTE_W;

  logic [BYTE_W-1:0] lane [NLANE];

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lane[g] = val[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    byte_o = '0;
    for (int i = 0; i < NLANE; i++) begin
      if (idx == IDX_W'(i)) byte_o = lane[i];
    end
  end
endmodule

// File: rtl/push_sp_bank.sv
`timescale 1ns/1ps
module push_sp_bank #(
  parameter int                  ADDR_W   = 24,
  parameter int                  SHORT_W  = 16,
  parameter int                  NB_L     = 3,
  parameter int                  NB_S     = 2,
  parameter logic [ADDR_W-1:0]   SPL_INIT = '0,
  parameter logic [SHORT_W-1:0]  SPS_INIT = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dec_long,
  input  logic               dec_short,
  output logic [ADDR_W-1:0]  sp_l,
  output logic [SHORT_W-1:0] sp_s
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sp_l <= SPL_INIT;
      sp_s <= SPS_INIT;
    end else begin
      if (dec_long)  sp_l <= sp_l - ADDR_W'(NB_L);
      if (dec_short) sp_s <= sp_s - SHORT_W'(NB_S);
    end
  end
endmodule

// File: rtl/dual_stack_pusher.sv
`timescale 1ns/1ps
module dual_stack_pusher
  import push_pkg::*;
#(
  parameter int                 ADDR_W   = 24,
  parameter int                 SHORT_W  = 16,
  parameter logic [ADDR_W-1:0]  SPL_INIT = '0,
  parameter logic [SHORT_W-1:0] SPS_INIT = '0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      push_req,
  input  logic [ADDR_W-1:0]         push_val,
  input  logic                      mode_long,
  input  logic [1:0]                sfx_sel,
  input  logic [ADDR_W-SHORT_W-1:0] mem_base,
  output logic                      busy,
  output logic                      mem_we,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [BYTE_W-1:0]         mem_wdata,
  output logic [ADDR_W-1:0]         sp_long,
  output logic [SHORT_W-1:0]        sp_short
);
  localparam int BASE_W = ADDR_W - SHORT_W;
  localparam int NB_L   = ADDR_W / BYTE_W;
  localparam int NB_S   = SHORT_W / BYTE_W;
  localparam int CW     = $clog2(NB_L + 1);

  // captured operands of the push in flight
  logic              busy_q, lng_q;
  logic [ADDR_W-1:0] val_q;
  logic [BASE_W-1:0] base_q;
  logic [CW-1:0]     off_q;
  logic [CW-1:0]     nb_q;

  // registered memory port
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] data_q;

  logic              accept, is_long_in, more, emit, last;
  logic              cur_long;
  logic [ADDR_W-1:0] cur_val;
  logic [BASE_W-1:0] cur_base;
  logic [CW-1:0]     cur_off, cur_nb, byte_idx;
  logic [ADDR_W-1:0] nxt_addr;
  logic [BYTE_W-1:0] nxt_byte;

  push_width_res u_wres (
    .mode_long (mode_long),
    .sfx_sel   (sfx_sel),
    .use_long  (is_long_in)
  );

  assign accept = push_req && !busy_q;
  assign nb_q   = lng_q ? CW'(NB_L) : CW'(NB_S);
  assign more   = busy_q && (off_q != nb_q);
  assign emit   = accept || more;

  // on the accept cycle the first byte is built straight from the inputs
  always_comb begin
    if (accept) begin
      cur_long = is_long_in;
      cur_val  = push_val;
      cur_base = mem_base;
      cur_off  = CW'(1);
    end else begin
      cur_long = lng_q;
      cur_val  = val_q;
      cur_base = base_q;
      cur_off  = off_q + CW'(1);
    end
    cur_nb   = cur_long ? CW'(NB_L) : CW'(NB_S);
    byte_idx = cur_nb - cur_off;
  end

  assign last = emit && (cur_off == cur_nb);

  push_addr_gen #(
    .ADDR_W  (ADDR_W),
    .SHORT_W (SHORT_W),
    .OFF_W   (CW)
  ) u_agen (
    .use_long (cur_long),
    .sp_l     (sp_long),
    .sp_s     (sp_short),
    .base     (cur_base),
    .off      (cur_off),
    .addr     (nxt_addr)
  );

  push_byte_pick #(
    .VAL_W (ADDR_W),
    .IDX_W (CW)
  ) u_bpick (
    .val    (cur_val),
    .idx    (byte_idx),
    .byte_o (nxt_byte)
  );

  // pointers move only on the edge that issues the final byte
  push_sp_bank #(
    .ADDR_W   (ADDR_W),
    .SHORT_W  (SHORT_W),
    .NB_L     (NB_L),
    .NB_S     (NB_S),
    .SPL_INIT (SPL_INIT),
    .SPS_INIT (SPS_INIT)
  ) u_spbank (
    .clk       (clk),
    .rst       (rst),
    .dec_long  (last && cur_long),
    .dec_short (last && !cur_long),
    .sp_l      (sp_long),
    .sp_s      (sp_short)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      lng_q  <= 1'b0;
      val_q  <= '0;
      base_q <= '0;
      off_q  <= '0;
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      we_q <= emit;
      if (emit) begin
        addr_q <= nxt_addr;
        data_q <= nxt_byte;
        off_q  <= cur_off;
      end
      if (accept) begin
        busy_q <= 1'b1;
        lng_q  <= is_long_in;
        val_q  <= push_val;
        base_q <= mem_base;
      end else if (busy_q && !more) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy      = busy_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;
endmodule

// File: rtl/push_seq_chk.sv
`timescale 1ns/1ps
module push_seq_chk #(
  parameter int ADDR_W  = 24,
  parameter int SHORT_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               busy,
  input logic               mem_we,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic [ADDR_W-1:0]  sp_long,
  input logic [SHORT_W-1:0] sp_short
);
  localparam int NB_L = ADDR_W / 8;
  localparam int NB_S = SHORT_W / 8;
  localparam int HI_W = ADDR_W - SHORT_W;
  localparam int RW   = $clog2(NB_L + 2);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)                run_q <= '0;
    else if (!mem_we)       run_q <= '0;
    else if (run_q <= RW'(NB_L)) run_q <= run_q + RW'(1);
  end

  // R10: no write strobe outside a push
  a_r10_we_needs_busy: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R10: back-to-back writes step down by one in the low part
  a_r10_addr_step: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |->
      (mem_addr[SHORT_W-1:0] == $past(mem_addr[SHORT_W-1:0]) - SHORT_W'(1)));

  // R3: base byte of a running push holds or borrows by one (long only)
  a_r3_base_steady: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |->
      ((mem_addr[ADDR_W-1:SHORT_W] == $past(mem_addr[ADDR_W-1:SHORT_W])) ||
       (mem_addr[ADDR_W-1:SHORT_W] == $past(mem_addr[ADDR_W-1:SHORT_W]) - HI_W'(1))));

  // R6: no run of writes longer than a long push
  a_r6_run_bound: assert property (@(posedge clk) disable iff (rst)
    run_q <= RW'(NB_L));

  // R6: first write coincides with busy rising, busy drops with the strobe
  a_r6_rise_writes: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> mem_we);
  a_r6_fall_after_write: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(mem_we) && !mem_we));

  // R2: the long pointer only ever moves down by a full long push
  a_r2_spl_step: assert property (@(posedge clk) disable iff (rst)
    (sp_long != $past(sp_long)) |-> (sp_long == $past(sp_long) - ADDR_W'(NB_L)));

  // R4: the short pointer only ever moves down by a full short push
  a_r4_sps_step: assert property (@(posedge clk) disable iff (rst)
    (sp_short != $past(sp_short)) |-> (sp_short == $past(sp_short) - SHORT_W'(NB_S)));

  // R2/R4: one push never moves both pointers
  a_r4_one_pointer: assert property (@(posedge clk) disable iff (rst)
    !((sp_long != $past(sp_long)) && (sp_short != $past(sp_short))));
endmodule

bind dual_stack_pusher push_seq_chk #(
  .ADDR_W  (ADDR_W),
  .SHORT_W (SHORT_W)
) u_push_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .sp_long  (sp_long),
  .sp_short (sp_short)
);

// File: tb/test_dual_stack_pusher.sv
`timescale 1ns/1ps
module test_dual_stack_pusher;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_req = 1'b0;
  logic [23:0] push_val = '0;
  logic        mode_long = 1'b0;
  logic [1:0]  sfx_sel = 2'b00;
  logic [7:0]  mem_base = '0;
  logic        busy, mem_we;
  logic [23:0] mem_addr, sp_long;
  logic [7:0]  mem_wdata;
  logic [15:0] sp_short;

  int vectors = 0;
  int miscompares = 0;
  int wr_seen = 0;
  bit done = 1'b0;

  logic [32:0] exp_q [$];
  logic [32:0] mon_e;
  logic [23:0] m_spl;
  logic [15:0] m_sps;

  always #10 clk = ~clk;  // 20 ns period, 50 MHz

  dual_stack_pusher #(
    .ADDR_W   (24),
    .SHORT_W  (16),
    .SPL_INIT (24'h000002),
    .SPS_INIT (16'h0001)
  ) i_dual_stack_pusher (
    .clk       (clk),
    .rst       (rst),
    .push_req  (push_req),
    .push_val  (push_val),
    .mode_long (mode_long),
    .sfx_sel   (sfx_sel),
    .mem_base  (mem_base),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .sp_long   (sp_long),
    .sp_short  (sp_short)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: every strobe must match the head of the scoreboard
  always @(negedge clk) begin
    if (!rst && mem_we === 1'b1) begin
      wr_seen++;
      check("R10", {31'd0, busy}, 32'd1);
      if (exp_q.size() == 0) begin
        vectors++;
        miscompares++;
        $display("FAIL R10 unexpected write act=%h exp=none", mem_addr);
      end else begin
        mon_e = exp_q.pop_front();
        check(mon_e[32] ? "R1" : "R3", {mem_addr, mem_wdata}, mon_e[31:0]);
      end
    end
  end

  // driver: model the push, queue the expected bytes, drive and disturb
  task automatic do_push(input logic [23:0] val, input logic mode, input logic [1:0] sfx,
                         input logic [7:0] base, input int inj_at);
    logic lng;
    int   nb, cnt, w0;
    lng = (sfx == 2'b10) || ((sfx != 2'b01) && mode);  // R5
    nb  = lng ? 3 : 2;
    for (int k = 1; k <= nb; k++) begin
      if (lng) exp_q.push_back({1'b1, m_spl - 24'(k), val[8*(nb-k) +: 8]});
      else     exp_q.push_back({1'b0, base, m_sps - 16'(k), val[8*(nb-k) +: 8]});
    end
    if (lng) m_spl = m_spl - 24'd3;
    else     m_sps = m_sps - 16'd2;
    w0 = wr_seen;

    @(negedge clk);
    push_req  = 1'b1;
    push_val  = val;
    mode_long = mode;
    sfx_sel   = sfx;
    mem_base  = base;
    @(negedge clk);
    push_req = 1'b0;
    cnt = 0;
    while (busy === 1'b1 && cnt < 8) begin
      cnt++;
      // R8: operands change under the running push
      push_val  = ~val;
      mode_long = ~mode;
      sfx_sel   = lng ? 2'b01 : 2'b10;
      mem_base  = ~base;
      push_req  = (cnt == inj_at);  // R7 stray request
      if (cnt == nb) begin
        check("R6", {8'd0, sp_long}, {8'd0, m_spl});
        check("R6", {16'd0, sp_short}, {16'd0, m_sps});
      end
      @(negedge clk);
    end
    push_req = 1'b0;
    check("R6", 32'(cnt), 32'(nb));
    check(lng ? "R2" : "R4", {8'd0, sp_long}, {8'd0, m_spl});
    check(lng ? "R4" : "R2", {16'd0, sp_short}, {16'd0, m_sps});
    check(lng ? "R1" : "R3", 32'(exp_q.size()), 32'd0);
    check(sfx != 2'b00 ? "R5" : "R8", 32'(wr_seen - w0), 32'(nb));
    @(negedge clk);
    check("R7", {30'd0, busy, mem_we}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check("R9", {31'd0, busy}, 32'd0);
    check("R9", {31'd0, mem_we}, 32'd0);
    check("R9", {8'd0, sp_long}, 32'h000002);
    check("R9", {16'd0, sp_short}, 32'h0001);
    m_spl = 24'h000002;
    m_sps = 16'h0001;

    do_push(24'hA1B2C3, 1'b1, 2'b00, 8'h7F, 0);  // R1 R2 long wrap below zero
    do_push(24'h123456, 1'b0, 2'b00, 8'h7F, 0);  // R3 R4 short wrap, base kept
    do_push(24'hDEAD42, 1'b1, 2'b01, 8'h10, 0);  // R5 short forced in long mode
    do_push(24'h0F1E2D, 1'b0, 2'b10, 8'h10, 0);  // R5 long forced in short mode
    do_push(24'h55AA33, 1'b0, 2'b11, 8'h22, 0);  // R5 reserved follows mode
    do_push(24'h778899, 1'b1, 2'b11, 8'h22, 0);  // R5 reserved follows mode
    do_push(24'hC0FFEE, 1'b1, 2'b00, 8'h01, 1);  // R7 R8 stray at first write
    do_push(24'hBEEF01, 1'b1, 2'b00, 8'h02, 2);  // R7 stray at middle write
    do_push(24'h246801, 1'b1, 2'b00, 8'h03, 3);  // R7 stray at final long write
    do_push(24'h13579B, 1'b0, 2'b00, 8'h04, 2);  // R7 stray at final short write
    for (int i = 0; i < 24; i++) begin
      do_push(24'($urandom), 1'($urandom), 2'($urandom), 8'($urandom), int'($urandom_range(0, 3)));
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule